// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing core of a two-channel pulse-width modulator. A 16-bit counter advances once per prescaled tick. It counts up, counts down, counts up then down, or holds its value, as a control field selects. Both channels share one active period register. Software can write that register directly, or through a shadow copy that is moved into it at the next zero of the count. Each channel has its own compare register: channel 0 uses compare A and channel 1 uses compare B.

A 16-bit register bus reaches the control, period and compare registers at fixed byte offsets. The block drives the live count and its direction. It also drives four strobes that mark the count stepping onto zero, onto the active period, onto compare A and onto compare B. Waveform logic further down the chip consumes these strobes.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, every event strobe is low, the control register reads 0x0003 (frozen), and the period and both compare registers read 0.
- R2: A write with `bus_wr` high lands at byte offset 0x00 (control), 0x0A (period), 0x12 (compare A) or 0x14 (compare B). Reads are combinational. Only control bits [12:7], [3] and [1:0] are kept; the other control bits read 0. Writes to any other offset are ignored, and reads there return 0.
- R3: The division ratio D is 2^ck × (hs == 0 ? 1 : 2 × hs). Here hs is control bits [9:7] and ck is control bits [12:10]. While counting, the counter steps exactly once every D clocks. The prescaler is held cleared while frozen, so the first step comes D clocks after the write that leaves frozen mode.
- R4: Between steps the count does not change.
- R5: With control bits [1:0] = 11 the count holds and no event strobe fires.
- R6: With mode 00 the count rises by one per step. Once it is at or above the active period, the next step takes it to 0.
- R7: With mode 01 the count falls by one per step. From 0 the next step loads the active period.
- R8: With mode 10 the count rises to the active period and then falls to 0, turning around at each end. With an active period of 0 it stays at 0.
- R9: With control bit 3 = 0, a period write goes only to the shadow copy. The shadow copy enters the active period on the step that takes the count to 0. Reads of offset 0x0A return the last written value.
- R10: With control bit 3 = 1, a period write also updates the active period at once.
- R11: Each event strobe is high for one clock, in the first cycle the count shows a value reached by a step. The strobes are for value 0, the active period, compare A and compare B. The period strobe compares against the active period held before any shadow copy made on the same step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| count | output | 16 | Current counter value |
| count_up | output | 1 | 1 while the counter is heading upward |
| ev_zero | output | 1 | Counter stepped onto 0 |
| ev_period | output | 1 | Counter stepped onto the active period |
| ev_cmpa | output | 1 | Counter stepped onto compare A (channel 0) |
| ev_cmpb | output | 1 | Counter stepped onto compare B (channel 1) |

## Verification
The bench runs the largest division ratio, 14 × 128. A prescaler that computed the high-speed factor as a power of two, or truncated its counter, would place the steps on the wrong cycles. A shadow period that differs from the active period shows whether the new value waits for the zero step. A design that loaded it early would wrap short on the first pass. A period of 0 in up mode must give zero and period strobes on every step. Up-down runs check that the counter turns at both ends rather than wrapping. A freeze that let the prescaler or counter run on would change the count during the hold window.

// File: rtl/pwm_tb_pkg.sv
`timescale 1ns/1ps
package pwm_tb_pkg;

  typedef enum logic [1:0] {
    MODE_UP   = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UPDN = 2'b10,
    MODE_HOLD = 2'b11
  } cnt_mode_e;

  // Byte offsets on the register bus
  localparam int unsigned OFS_CTRL = 32'h00;
  localparam int unsigned OFS_PRD  = 32'h0A;
  localparam int unsigned OFS_CMPA = 32'h12;
  localparam int unsigned OFS_CMPB = 32'h14;

  // Control field positions
  localparam int unsigned CTRL_LOAD_BIT = 3;
  localparam int unsigned CTRL_HS_LSB   = 7;
  localparam int unsigned CTRL_CK_LSB   = 10;

  // Total clock division: the high-speed factor (1, or twice its code)
  // shifted left by the coarse code.
  function automatic int unsigned div_total(int unsigned hs_code, int unsigned ck_code);
    int unsigned hs_fac;
    hs_fac = (hs_code == 0) ? 1 : 2 * hs_code;
    return hs_fac << ck_code;
  endfunction

endpackage

// File: rtl/pwm_tb_regs.sv
`timescale 1ns/1ps
module pwm_tb_regs
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              shadow_load,
  output cnt_mode_e         mode,
  output logic [CODE_W-1:0] hs_code,
  output logic [CODE_W-1:0] ck_code,
  output logic [CNT_W-1:0]  prd_active,
  output logic [CNT_W-1:0]  cmp_a,
  output logic [CNT_W-1:0]  cmp_b
);

  logic              imm_q;
  logic [CNT_W-1:0]  prd_shadow;
  logic [CNT_W-1:0]  ctrl_view;

  logic sel_ctrl, sel_prd, sel_cmpa, sel_cmpb;
  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_prd  = (bus_addr == ADDR_W'(OFS_PRD));
  assign sel_cmpa = (bus_addr == ADDR_W'(OFS_CMPA));
  assign sel_cmpb = (bus_addr == ADDR_W'(OFS_CMPB));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MODE_HOLD;
      imm_q   <= 1'b0;
      hs_code <= '0;
      ck_code <= '0;
    end else if (bus_wr && sel_ctrl) begin
      mode    <= cnt_mode_e'(bus_wdata[1:0]);
      imm_q   <= bus_wdata[CTRL_LOAD_BIT];
      hs_code <= bus_wdata[CTRL_HS_LSB +: CODE_W];
      ck_code <= bus_wdata[CTRL_CK_LSB +: CODE_W];
    end
  end

  // Period: shadow always takes the write; active takes it at once only in
  // immediate mode, otherwise on the zero step.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_shadow <= '0;
      prd_active <= '0;
    end else begin
      if (bus_wr && sel_prd) prd_shadow <= bus_wdata;
      if (bus_wr && sel_prd && imm_q) prd_active <= bus_wdata;
      else if (shadow_load && !imm_q) prd_active <= prd_shadow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
    end else begin
      if (bus_wr && sel_cmpa) cmp_a <= bus_wdata;
      if (bus_wr && sel_cmpb) cmp_b <= bus_wdata;
    end
  end

  always_comb begin
    ctrl_view                              = '0;
    ctrl_view[1:0]                         = mode;
    ctrl_view[CTRL_LOAD_BIT]               = imm_q;
    ctrl_view[CTRL_HS_LSB +: CODE_W]       = hs_code;
    ctrl_view[CTRL_CK_LSB +: CODE_W]       = ck_code;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)      bus_rdata = ctrl_view;
    else if (sel_prd)  bus_rdata = prd_shadow;
    else if (sel_cmpa) bus_rdata = cmp_a;
    else if (sel_cmpb) bus_rdata = cmp_b;
  end

endmodule

// File: rtl/pwm_tb_prescale.sv
`timescale 1ns/1ps
module pwm_tb_prescale
  import pwm_tb_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] hs_code,
  input  logic [CODE_W-1:0] ck_code,
  output logic              tick
);

  localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;
  localparam int unsigned MAX_DIV  = div_total(MAX_CODE, MAX_CODE);
  localparam int          DIV_W    = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] div_m1;
  logic [DIV_W-1:0] pre_cnt;
  logic             at_end;

  assign div_m1 = DIV_W'(div_total(32'(hs_code), 32'(ck_code)) - 1);
  // ">=" also covers a ratio lowered while the counter is past the new end
  assign at_end = (pre_cnt >= div_m1);
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_cnt <= '0;
    else if (!run)    pre_cnt <= '0;
    else if (at_end)  pre_cnt <= '0;
    else              pre_cnt <= pre_cnt + DIV_W'(1);
  end

endmodule

// File: rtl/pwm_tb_counter.sv
`timescale 1ns/1ps
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up,
  output logic             running,
  output logic             step,
  output logic [CNT_W-1:0] nxt
);

  logic dir_n;

  assign running = (mode != MODE_HOLD);
  assign step    = tick && running;

  always_comb begin
    nxt   = cnt;
    dir_n = dir_up;
    unique case (mode)
      MODE_UP: begin
        dir_n = 1'b1;
        nxt   = (cnt >= prd) ? '0 : cnt + CNT_W'(1);
      end
      MODE_DOWN: begin
        dir_n = 1'b0;
        nxt   = (cnt == '0) ? prd : cnt - CNT_W'(1);
      end
      MODE_UPDN: begin
        if (dir_up) begin
          if (cnt >= prd) begin
            dir_n = 1'b0;
            nxt   = (cnt == '0) ? '0 : cnt - CNT_W'(1);
          end else begin
            nxt   = cnt + CNT_W'(1);
          end
        end else begin
          if (cnt == '0) begin
            dir_n = 1'b1;
            nxt   = (prd == '0) ? '0 : CNT_W'(1);
          end else begin
            nxt   = cnt - CNT_W'(1);
          end
        end
      end
      default: begin
        nxt   = cnt;
        dir_n = dir_up;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (step) begin
      cnt    <= nxt;
      dir_up <= dir_n;
    end
  end

endmodule

// File: rtl/pwm_tb_match.sv
`timescale 1ns/1ps
module pwm_tb_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] nxt,
  input  logic [CNT_W-1:0] ref_val,
  output logic             hit
);

  always_ff @(posedge clk) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= step && (nxt == ref_val);
  end

endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [CNT_W-1:0]  count,
  output logic              count_up,
  output logic              ev_zero,
  output logic              ev_period,
  output logic              ev_cmpa,
  output logic              ev_cmpb
);

  localparam int NUM_EV = 4;  // zero, period, compare A, compare B

  // Named internal events, visible to the bound checker
  cnt_mode_e                     mode;
  logic [CODE_W-1:0]             hs_code, ck_code;
  logic [CNT_W-1:0]              prd_active, cmp_a, cmp_b;
  logic                          tick, running, step, shadow_load;
  logic [CNT_W-1:0]              nxt;
  logic [NUM_EV-1:0][CNT_W-1:0]  ev_ref;
  logic [NUM_EV-1:0]             ev_vec;

  assign shadow_load = step && (nxt == '0);

  pwm_tb_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .shadow_load(shadow_load),
    .mode(mode), .hs_code(hs_code), .ck_code(ck_code),
    .prd_active(prd_active), .cmp_a(cmp_a), .cmp_b(cmp_b)
  );

  pwm_tb_prescale #(.CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running),
    .hs_code(hs_code), .ck_code(ck_code), .tick(tick)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .prd(prd_active),
    .cnt(count), .dir_up(count_up), .running(running), .step(step), .nxt(nxt)
  );

  assign ev_ref[0] = '0;
  assign ev_ref[1] = prd_active;
  assign ev_ref[2] = cmp_a;
  assign ev_ref[3] = cmp_b;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    pwm_tb_match #(.CNT_W(CNT_W)) u_match (
      .clk(clk), .rst_n(rst_n), .step(step), .nxt(nxt),
      .ref_val(ev_ref[g]), .hit(ev_vec[g])
    );
  end

  assign ev_zero   = ev_vec[0];
  assign ev_period = ev_vec[1];
  assign ev_cmpa   = ev_vec[2];
  assign ev_cmpb   = ev_vec[3];

endmodule

// File: rtl/pwm_timebase_chk.sv
`timescale 1ns/1ps
module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] prd_active,
  input logic             ev_zero,
  input logic             ev_period,
  input logic             ev_cmpa,
  input logic             ev_cmpb
);

  a_r4_no_move_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(count));

  a_r5_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b11) |-> $stable(count));

  a_r6_up_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $past(mode) == 2'b00 && $past(count) >= $past(prd_active)) |-> (count == '0));

  a_r11_zero_strobe_value: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero |-> (count == '0));

  a_r11_period_strobe_value: assert property (@(posedge clk) disable iff (!rst_n)
    ev_period |-> (count == $past(prd_active)));

  a_r11_cmp_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmpa || ev_cmpb) |-> $past(tick));

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .count(count),
  .prd_active(prd_active), .ev_zero(ev_zero), .ev_period(ev_period),
  .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb)
);

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] count;
  logic        count_up;
  logic        ev_zero, ev_period, ev_cmpa, ev_cmpb;

  always #10 clk = ~clk;  // 50 MHz

  pwm_timebase i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(count), .count_up(count_up),
    .ev_zero(ev_zero), .ev_period(ev_period), .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    int unsigned at;
    logic [15:0] cnt;
    logic [3:0]  ev;   // {cmpb, cmpa, period, zero}
    string       req;
  } item_t;
  item_t sb[$];

  // Reference state, kept from the requirements
  logic [15:0] m_cnt, m_act, m_shd, m_ca, m_cb;
  logic        m_up, m_imm;
  logic [1:0]  m_mode;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_act = 0; m_shd = 0; m_ca = 0; m_cb = 0;
    m_up = 1'b1; m_imm = 1'b0; m_mode = 2'b11;
  endtask

  // One write; returns the index of the clock edge that took it
  task automatic wreg(input logic [4:0] a, input logic [15:0] d, output int unsigned at);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    at = cyc;
    case (a)
      5'h00: begin m_mode = d[1:0]; m_imm = d[3]; end
      5'h0A: begin m_shd = d; if (m_imm) m_act = d; end
      5'h12: m_ca = d;
      5'h14: m_cb = d;
      default: ;
    endcase
  endtask

  task automatic rreg(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Reference step of the counter, written from R6..R9 and R11
  task automatic model_step(output logic [15:0] c, output logic [3:0] ev);
    logic [15:0] n;
    logic [15:0] act_before;
    act_before = m_act;
    n = m_cnt;
    if (m_mode == 2'b00) begin
      m_up = 1'b1;
      n = (m_cnt < m_act) ? m_cnt + 16'd1 : 16'd0;
    end else if (m_mode == 2'b01) begin
      m_up = 1'b0;
      n = (m_cnt != 0) ? m_cnt - 16'd1 : m_act;
    end else if (m_mode == 2'b10) begin
      if (m_up && m_cnt < m_act) n = m_cnt + 16'd1;
      else if (m_up) begin
        m_up = 1'b0;
        n = (m_cnt != 0) ? m_cnt - 16'd1 : 16'd0;
      end else if (m_cnt != 0) n = m_cnt - 16'd1;
      else begin
        m_up = 1'b1;
        n = (m_act != 0) ? 16'd1 : 16'd0;
      end
    end
    ev = {n == m_cb, n == m_ca, n == act_before, n == 16'd0};
    if (n == 0 && !m_imm) m_act = m_shd;
    m_cnt = n;
    c = n;
  endtask

  // Driver: starts a counting mode, queues the expected trace, waits for it
  task automatic run_case(input logic [1:0] mode, input int hs, input int ck,
                          input int steps, input string req);
    int unsigned e;
    int unsigned d;
    logic [15:0] c;
    logic [3:0]  ev;
    d = (hs == 0 ? 1 : 2 * hs) * (1 << ck);
    wreg(5'h00, {3'b000, 3'(ck), 3'(hs), 3'b000, m_imm, 1'b0, mode}, e);
    for (int k = 1; k <= steps; k++) begin
      model_step(c, ev);
      sb.push_back('{at: e + k * d, cnt: c, ev: ev, req: req});
      if (d > 1) sb.push_back('{at: e + k * d + 1, cnt: c, ev: 4'b0000, req: "R4"});
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops expected items and compares them in their cycle
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() != 0 && sb[0].at <= cyc) begin
        item_t it;
        it = sb.pop_front();
        if (it.at < cyc) check({it.req, " missed"}, 32'(cyc), 32'(it.at));
        else check(it.req, {12'h0, ev_cmpb, ev_cmpa, ev_period, ev_zero, count},
                   {12'h0, it.ev, it.cnt});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int unsigned e;
    logic [15:0] c0;
    bit held;

    do_reset();
    @(negedge clk);
    check("R1 count", 32'(count), 32'h0);
    check("R1 events", 32'({ev_cmpb, ev_cmpa, ev_period, ev_zero}), 32'h0);
    rreg(5'h00, rd); check("R1 ctrl", 32'(rd), 32'h0003);
    rreg(5'h0A, rd); check("R1 period", 32'(rd), 32'h0);
    rreg(5'h14, rd); check("R1 cmpb", 32'(rd), 32'h0);

    // R2: field mask, unmapped offset
    wreg(5'h00, 16'hFFFF, e);
    rreg(5'h00, rd); check("R2 ctrl mask", 32'(rd), 32'h1F8B);
    wreg(5'h02, 16'hFFFF, e);
    rreg(5'h02, rd); check("R2 unmapped read", 32'(rd), 32'h0);
    rreg(5'h00, rd); check("R2 ctrl after stray write", 32'(rd), 32'h1F8B);
    rreg(5'h0A, rd); check("R2 period after stray write", 32'(rd), 32'h0);

    // Up mode, immediate period load, ratio 1
    do_reset();
    wreg(5'h00, 16'h000B, e);
    wreg(5'h0A, 16'd5, e);
    wreg(5'h12, 16'd2, e);
    wreg(5'h14, 16'd4, e);
    run_case(2'b00, 0, 0, 14, "R6 R10");

    // R5: freeze holds the count
    wreg(5'h00, 16'h000B, e);
    c0 = count;
    held = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (count !== c0 || {ev_cmpb, ev_cmpa, ev_period, ev_zero} !== 4'b0) held = 1'b0;
    end
    check("R5 freeze", 32'(held), 32'h1);

    // Down mode, ratio 6*2 = 12
    do_reset();
    wreg(5'h00, 16'h000B, e);
    wreg(5'h0A, 16'd4, e);
    wreg(5'h12, 16'd3, e);
    wreg(5'h14, 16'd1, e);
    run_case(2'b01, 3, 1, 12, "R7 R3");

    // Up-down with shadow load, ratio 4
    do_reset();
    wreg(5'h00, 16'h0003, e);
    wreg(5'h0A, 16'd3, e);
    rreg(5'h0A, rd); check("R9 shadow readback", 32'(rd), 32'd3);
    wreg(5'h12, 16'd2, e);
    wreg(5'h14, 16'd3, e);
    run_case(2'b10, 0, 2, 16, "R8");

    // Shadow defers a new period until the zero step, ratio 2
    do_reset();
    wreg(5'h00, 16'h000B, e);
    wreg(5'h0A, 16'd6, e);
    wreg(5'h00, 16'h0003, e);
    wreg(5'h0A, 16'd2, e);
    wreg(5'h12, 16'd1, e);
    wreg(5'h14, 16'd6, e);
    run_case(2'b00, 1, 0, 12, "R9");

    // Largest ratio 14*128
    do_reset();
    wreg(5'h00, 16'h000B, e);
    wreg(5'h0A, 16'd2, e);
    wreg(5'h12, 16'd1, e);
    wreg(5'h14, 16'd2, e);
    run_case(2'b00, 7, 7, 3, "R3 max");

    // Period 0 in up mode: every step is a zero and a period event
    do_reset();
    wreg(5'h00, 16'h000B, e);
    run_case(2'b00, 2, 0, 4, "R11");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule